// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Controller

This block watches 32 input pins arranged as four groups of eight. Every pin passes through a two-flop synchronizer. A change of level is found by comparing the synchronized value with the value it had one cycle earlier. Each group has its own 8-bit enable mask. When an enabled pin of a group changes level, rising or falling, the group starts a qualification window. At the end of the window the group compares the masked pin levels with the levels it captured before the change. The group's flag is set only if they still differ, so a short glitch that returns to its starting level raises nothing.

Detection uses only the pin level. Software that drives a pin it also watches can therefore raise an interrupt on itself. Each flag is gated by a per-group enable bit to form one interrupt request per group. A flag is cleared by writing 1 to its bit or by pulsing the group's acknowledge input. A small register port with a combinational read lets software reach the masks, the flags and the enables. The whole block runs in one clock domain.

Top module: `pcint_ctrl`

## Requirements
- R1: After reset, every mask, the flag register and the enable register read 0, and all four requests are low.
- R2: A change of level on an unmasked-in pin (mask bit 1), rising or falling, sets its group's flag. The flag is first visible QUAL_CYC+3 clock cycles after the pin changes, and not one cycle earlier.
- R3: A change of level on a pin whose mask bit is 0 sets no flag.
- R4: Pin n belongs to group n/8. Its mask is bit n%8 of the mask register at address n/8, and it sets flag bit n/8 only.
- R5: If a pin returns to its starting level before the qualification window ends, no flag is set.
- R6: Writing to address 4 clears each flag bit whose written data bit is 1. Data bits that are 0 leave their flags unchanged.
- R7: A high ack_in[g] for one cycle clears flag g.
- R8: When a flag is set and cleared in the same cycle, by a register write or by ack_in, the flag stays set.
- R9: irq[g] is high exactly when flag g and enable bit g are both 1.
- R10: Register map. Addresses 0 to 3 are the group masks (read/write). Address 4 holds the flags in bits 3:0. Address 5 holds the enables in bits 3:0 (read/write). Unused bits and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pin_in | input | 32 | Watched pins; group g is bits 8g+7:8g |
| ack_in | input | 4 | Per-group flag clear pulse |
| irq | output | 4 | Per-group interrupt request |

## Verification
A qualified change can set a flag in the same cycle that software or the acknowledge input clears that flag. The bench computes the exact edge at which the set takes effect, which is QUAL_CYC+3 edges after the pin is driven. It places a write-one-to-clear on that edge, and in a second run an ack_in pulse. After each collision it expects the flag to read as set. Separate runs check that each clear path works on its own, so a collision that wrongly let the clear win cannot pass unnoticed.

// File: rtl/pcint_pkg.sv
// Shared constants for the grouped pin change interrupt controller.
// Assumes at most four groups, so the mask addresses fit below the flag address.
package pcint_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd5;
endpackage

// File: rtl/pcint_sync.sv
// Two-flop synchronizer for a vector of pins, plus a third stage that holds
// the synchronized value from one cycle earlier for edge comparison.
// Assumes the pins are idle low at reset.
module pcint_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prev_q;

    // Move each pin through two stages, then keep one more cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/pcint_group.sv
// One group of pins: masked change detection and a qualification window.
// A masked change opens a window of QUAL_CYC cycles and captures the levels
// seen before the change. On the last window cycle set_o pulses only if the
// masked levels still differ from that capture. QUAL_CYC = 0 sets at once.
module pcint_group #(
    parameter int GRP_W    = 8,
    parameter int QUAL_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] lvl_i,
    input  logic [GRP_W-1:0] prev_i,
    input  logic [GRP_W-1:0] mask_i,
    output logic             set_o
);
    logic [GRP_W-1:0] tog;

    // Masked change of level on any pin of the group.
    always_comb tog = (lvl_i ^ prev_i) & mask_i;

    generate
        if (QUAL_CYC == 0) begin : g_direct
            assign set_o = |tog;
        end else begin : g_win
            localparam int CNT_W = $clog2(QUAL_CYC + 1);
            localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(QUAL_CYC);
            localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

            logic [CNT_W-1:0] cnt;
            logic [GRP_W-1:0] ref_lvl;

            // Open or reopen the window on a masked change, otherwise count it down.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt     <= '0;
                    ref_lvl <= '0;
                end else if ((cnt <= CNT_ONE) && (|tog)) begin
                    cnt     <= CNT_LOAD;
                    ref_lvl <= prev_i;
                end else if (cnt != '0) begin
                    cnt <= cnt - CNT_ONE;
                end
            end

            // Recheck the masked levels against the capture on the last window cycle.
            always_comb set_o = (cnt == CNT_ONE) &&
                                ((lvl_i & mask_i) != (ref_lvl & mask_i));

            AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
                ((cnt == '0) && !(|tog)) |=> !set_o); // R5
        end
    endgenerate
endmodule

// File: rtl/pcint_regs.sv
// Register file: group masks, write-one-to-clear flags and request enables,
// with a combinational read mux. Assumes the data width equals the group width
// and that there are no more groups than data bits.
module pcint_regs
    import pcint_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     we_i,
    input  logic [GRP_W-1:0]         wdata_i,
    output logic [GRP_W-1:0]         rdata_o,
    input  logic [NUM_GRP-1:0]       set_i,
    input  logic [NUM_GRP-1:0]       ack_i,
    output logic [NUM_GRP*GRP_W-1:0] mask_o,
    output logic [NUM_GRP-1:0]       irq_o
);
    localparam int PAD_W = GRP_W - NUM_GRP;

    logic [GRP_W-1:0]   mask_q [NUM_GRP];
    logic [NUM_GRP-1:0] flag_q;
    logic [NUM_GRP-1:0] en_q;
    logic [NUM_GRP-1:0] clr;
    logic               wr_flag;
    logic               wr_en;

    // Decode writes to the flag and enable registers.
    always_comb begin
        wr_flag = we_i && (addr_i == A_FLAG);
        wr_en   = we_i && (addr_i == A_EN);
    end

    // Collect every clear source for the flags.
    always_comb clr = ack_i | (wr_flag ? wdata_i[NUM_GRP-1:0] : '0);

    genvar g;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_mask
            // Hold the mask of group g, written at address g.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask_q[g] <= '0;
                end else if (we_i && (addr_i == ADDR_W'(g))) begin
                    mask_q[g] <= wdata_i;
                end
            end
            assign mask_o[g*GRP_W +: GRP_W] = mask_q[g];
        end
    endgenerate

    // Update the flags; a set in the same cycle wins over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr) | set_i;
        end
    end

    // Hold the per-group request enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wdata_i[NUM_GRP-1:0];
        end
    end

    // Gate each flag with its enable to form the request.
    always_comb irq_o = flag_q & en_q;

    // Select read data by address; unused addresses return zero.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_GRP; i++) begin
            if (addr_i == ADDR_W'(i)) rdata_o = mask_q[i];
        end
        if (addr_i == A_FLAG) rdata_o = {{PAD_W{1'b0}}, flag_q};
        if (addr_i == A_EN)   rdata_o = {{PAD_W{1'b0}}, en_q};
    end

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i))); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_i & ~set_i)) |=> ((flag_q & $past(ack_i & ~set_i)) == '0)); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && |(wdata_i[NUM_GRP-1:0] & ~set_i))
        |=> ((flag_q & $past(wdata_i[NUM_GRP-1:0] & ~set_i)) == '0)); // R6
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wdata_i[NUM_GRP-1:0]))); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0)); // R1
endmodule

// File: rtl/pcint_ctrl.sv
// Top level of the grouped pin change interrupt controller. Synchronizes all
// pins, runs one detector per group of GRP_W pins and feeds the register file.
// Assumes one clock domain and NUM_GRP <= 4.
module pcint_ctrl
    import pcint_pkg::*;
#(
    parameter int NUM_GRP  = 4,
    parameter int GRP_W    = 8,
    parameter int QUAL_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_we,
    input  logic [GRP_W-1:0]         reg_wdata,
    output logic [GRP_W-1:0]         reg_rdata,
    input  logic [NUM_GRP*GRP_W-1:0] pin_in,
    input  logic [NUM_GRP-1:0]       ack_in,
    output logic [NUM_GRP-1:0]       irq
);
    localparam int PIN_W = NUM_GRP * GRP_W;

    logic [PIN_W-1:0]   lvl;
    logic [PIN_W-1:0]   prev;
    logic [PIN_W-1:0]   mask;
    logic [NUM_GRP-1:0] set;

    pcint_sync #(.W(PIN_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_grp
            pcint_group #(.GRP_W(GRP_W), .QUAL_CYC(QUAL_CYC)) u_grp (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (lvl[g*GRP_W +: GRP_W]),
                .prev_i (prev[g*GRP_W +: GRP_W]),
                .mask_i (mask[g*GRP_W +: GRP_W]),
                .set_o  (set[g])
            );
        end
    endgenerate

    pcint_regs #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .we_i    (reg_we),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .set_i   (set),
        .ack_i   (ack_in),
        .mask_o  (mask),
        .irq_o   (irq)
    );
endmodule

// File: tb/sim_pcint_ctrl.sv
module sim_pcint_ctrl;
    localparam int QUAL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [31:0] pin_in = '0;
    logic [3:0]  ack_in = '0;
    logic [3:0]  irq;

    typedef struct {
        bit       is_irq;
        logic [7:0] exp;
        string    tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcint_ctrl #(.QUAL_CYC(QUAL)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .ack_in(ack_in), .irq(irq)
    );

    // Driver side: queue an expectation against a register read or the requests.
    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string t);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = t;
        q.push_back(it);
        @(posedge clk);
    endtask

    task automatic expect_irq(input logic [3:0] e, input string t);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {4'b0, e}; it.tag = t;
        q.push_back(it);
        @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic flip(input int p);
        @(negedge clk);
        pin_in[p] = ~pin_in[p];
    endtask

    task automatic settle();
        repeat (QUAL + 6) @(posedge clk);
    endtask

    // Monitor: pop expectations and compare against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                act = it.is_irq ? {4'b0, irq} : reg_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values, R10 unused address
        for (int a = 0; a < 6; a++) expect_reg(3'(a), 8'h00, "R1 reset reg");
        expect_irq(4'h0, "R1 reset irq");
        expect_reg(3'd6, 8'h00, "R10 unused address");

        // R10 register map
        wr(3'd0, 8'h01); wr(3'd1, 8'h80); wr(3'd2, 8'hFF); wr(3'd3, 8'h10);
        wr(3'd5, 8'hFF);
        expect_reg(3'd0, 8'h01, "R10 mask0");
        expect_reg(3'd1, 8'h80, "R10 mask1");
        expect_reg(3'd3, 8'h10, "R10 mask3");
        expect_reg(3'd5, 8'h0F, "R10 enable upper bits zero");

        // R2 rising change on pin 0, exact latency
        flip(0);
        repeat (QUAL + 2) @(posedge clk);
        expect_reg(3'd4, 8'h00, "R2 flag not early");
        expect_reg(3'd4, 8'h01, "R2 flag on time");
        expect_irq(4'h1, "R9 irq with enable");

        // R6 write zero leaves flag, write one clears
        wr(3'd4, 8'h00);
        expect_reg(3'd4, 8'h01, "R6 zero write no effect");
        wr(3'd4, 8'h01);
        expect_reg(3'd4, 8'h00, "R6 one write clears");

        // R2 falling change, R7 ack clears
        flip(0); settle();
        expect_reg(3'd4, 8'h01, "R2 falling sets flag");
        @(negedge clk) ack_in = 4'h1;
        @(negedge clk) ack_in = 4'h0;
        expect_reg(3'd4, 8'h00, "R7 ack clears");

        // R3 masked-out pins
        flip(1); settle();
        expect_reg(3'd4, 8'h00, "R3 pin1 masked out");
        flip(9); settle();
        expect_reg(3'd4, 8'h00, "R3 pin9 masked out");

        // R4 group mapping
        flip(15); settle();
        expect_reg(3'd4, 8'h02, "R4 pin15 group1");
        wr(3'd4, 8'h0F);
        flip(28); settle();
        expect_reg(3'd4, 8'h08, "R4 pin28 group3");
        wr(3'd4, 8'h0F);

        // R5 short pulse rejected
        flip(16);
        repeat (2) @(posedge clk);
        flip(16); settle();
        expect_reg(3'd4, 8'h00, "R5 glitch rejected");

        // R9 enable gating
        wr(3'd5, 8'h00);
        flip(16); settle();
        expect_reg(3'd4, 8'h04, "R9 flag set while disabled");
        expect_irq(4'h0, "R9 irq gated off");
        wr(3'd5, 8'h04);
        expect_irq(4'h4, "R9 irq gated on");
        wr(3'd4, 8'h0F);

        // R8 set collides with write-one-to-clear
        flip(17);
        repeat (QUAL + 2) @(posedge clk);
        @(negedge clk);
        reg_addr = 3'd4; reg_wdata = 8'h04; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk) reg_we = 1'b0;
        expect_reg(3'd4, 8'h04, "R8 set wins over write clear");
        wr(3'd4, 8'h0F);

        // R8 set collides with ack
        flip(17);
        repeat (QUAL + 2) @(posedge clk);
        @(negedge clk) ack_in = 4'h4;
        @(posedge clk);
        @(negedge clk) ack_in = 4'h0;
        expect_reg(3'd4, 8'h04, "R8 set wins over ack");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule